// File: doc/BRIEF.md
# SDRAM Command Sequencing Controller

This block connects a single-word host request port to a single-data-rate SDRAM that has four banks, 4096 rows per bank and 256 columns of 32-bit words. After reset it holds the memory idle for a programmable settling time. It then closes all banks, runs two refresh cycles and writes the mode register. After that it accepts one host request at a time.

Each request carries a 22-bit word address, a write flag and write data. The address is split into bank, row and column. The controller opens the row, and once the row-to-column delay has passed it issues the column command with auto-precharge requested, so the row closes by itself. Read data is captured a fixed CAS latency after the read command and is returned with a one-cycle valid strobe.

A periodic timer marks a refresh as due. The refresh then wins over waiting host traffic: the controller closes every bank first and then issues the refresh. All command spacing is counted in clock cycles and set by parameters.

Top module: `sdram_cmd_ctrl`

## Requirements
- R1: While reset is held and until the mode register has been written, the pins carry NOP (cs_n,ras_n,cas_n,we_n = 0,1,1,1), all four DQM bits are high and req_ready is low. During reset CKE is low, and rsp_valid is low.
- R2: After reset is released, exactly INIT_CYCLES NOP cycles pass first. The controller then issues precharge (0,0,1,0) with A10 high. T_RP cycles later it issues refresh (0,0,0,1), and T_RFC cycles after that a second refresh. T_RFC cycles after the second refresh it issues the mode load (0,0,0,0) with BA=0 and A = CAS_LAT<<4, which gives burst length 1 and sequential order.
- R3: The host address maps as bank = addr[21:20], row = addr[19:8], col = addr[7:0]. Activate (0,0,1,1) drives the bank on BA and the row on A11..A0, and goes only to a bank with no open row. The read (0,1,0,1) or write (0,1,0,0) command targets the bank opened by the preceding activate, with the column on A7..A0, A10 high (auto-precharge) and A11, A9, A8 low.
- R4: The read or write command follows its activate by exactly T_RCD cycles.
- R5: Write data is driven on DQ with the output enable high in the write-command cycle only. In that cycle DQM is 0000.
- R6: For a read, DQM is 0000 in the cycle CAS_LAT-2 after the read command. DQM is 1111 in every cycle that is neither this one nor a write-command cycle. rsp_valid is high for exactly one cycle, CAS_LAT+1 cycles after the read command, carrying the DQ value present at the end of cycle CAS_LAT.
- R7: After a write command no other command is issued for T_WR+T_RP cycles. After a read command no other command is issued for CAS_LAT+T_RP cycles.
- R8: Refreshes recur every REF_INTERVAL cycles, within the time one access plus one precharge takes. Each refresh is preceded by a precharge with A10 high exactly T_RP cycles earlier, and nothing but NOP follows for T_RFC-1 cycles.
- R9: Once a refresh is due it takes priority over a waiting request. req_ready stays low from the precharge-all until the refresh command.
- R10: Each req_valid/req_ready handshake causes exactly one activate. Responses return in request order and carry the data last written to that address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | Word address {bank, row, col} |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data strobe |
| rsp_rdata | output | 32 | Read data |
| sd_cke | output | 1 | Clock enable |
| sd_cs_n | output | 1 | Chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_a | output | 12 | Address bus |
| sd_dqm | output | 4 | Byte masks, high = masked |
| sd_dq_o | output | 32 | Data out |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_i | input | 32 | Data in |

## Verification
The memory model drives DQ with the correct word only in the single cycle the capture should happen, and with junk in every other cycle. A controller that captures one cycle early or late therefore returns a wrong word and fails the scoreboard. The model also checks the exact spacing of every command: the four init steps, activate to column, the recovery gap after auto-precharge, and precharge-all to refresh. An off-by-one delay counter shows up as a spacing miscompare. Long runs of back-to-back requests check that refresh is never starved, since a controller that let host traffic win would break the refresh-gap bound. Addresses at the bank, row and column extremes catch a mis-sliced address map, which would land writes on the wrong bank or row.

// File: rtl/sdram_cmd_ctrl.sv
module sdram_cmd_ctrl #(
  parameter int INIT_CYCLES  = 25000,
  parameter int REF_INTERVAL = 1950,
  parameter int T_RCD        = 3,
  parameter int T_RP         = 3,
  parameter int T_RFC        = 9,
  parameter int T_WR         = 2,
  parameter int T_MRD        = 2,
  parameter int CAS_LAT      = 3,
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 32
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            req_valid,
  output logic                            req_ready,
  input  logic                            req_write,
  input  logic [BANK_W+ROW_W+COL_W-1:0]   req_addr,
  input  logic [DATA_W-1:0]               req_wdata,
  output logic                            rsp_valid,
  output logic [DATA_W-1:0]               rsp_rdata,
  output logic                            sd_cke,
  output logic                            sd_cs_n,
  output logic                            sd_ras_n,
  output logic                            sd_cas_n,
  output logic                            sd_we_n,
  output logic [BANK_W-1:0]               sd_ba,
  output logic [ROW_W-1:0]                sd_a,
  output logic [DATA_W/8-1:0]             sd_dqm,
  output logic [DATA_W-1:0]               sd_dq_o,
  output logic                            sd_dq_oe,
  input  logic [DATA_W-1:0]               sd_dq_i
);

  localparam int MAXD  = (INIT_CYCLES > REF_INTERVAL) ? INIT_CYCLES : REF_INTERVAL;
  localparam int CNT_W = $clog2(MAXD + 1) + 1;
  localparam int RC_W  = $clog2(REF_INTERVAL + 1);
  localparam int MSK_W = DATA_W / 8;

  localparam logic [3:0] CMD_NOP = 4'b0111;
  localparam logic [3:0] CMD_ACT = 4'b0011;
  localparam logic [3:0] CMD_RD  = 4'b0101;
  localparam logic [3:0] CMD_WR  = 4'b0100;
  localparam logic [3:0] CMD_PRE = 4'b0010;
  localparam logic [3:0] CMD_REF = 4'b0001;
  localparam logic [3:0] CMD_MRS = 4'b0000;

  typedef enum logic [2:0] {
    ST_WAIT, ST_IPRE, ST_IREF1, ST_IREF2, ST_IMRS, ST_IDLE, ST_COL, ST_RREF
  } state_t;

  state_t               st;
  logic [CNT_W-1:0]     cnt;
  logic [RC_W-1:0]      ref_cnt;
  logic                 ref_due;
  logic [3:0]           cmd;
  logic                 wr_q;
  logic [COL_W-1:0]     col_q;
  logic [DATA_W-1:0]    wdata_q;
  logic                 wr_cyc;
  logic [CAS_LAT:0]     rd_sr;
  logic                 init_done;

  assign {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = cmd;
  assign init_done = (st == ST_IDLE) || (st == ST_COL) || (st == ST_RREF);
  assign req_ready = (st == ST_IDLE) && (cnt == '0) && !ref_due;
  assign sd_dqm    = (wr_cyc || rd_sr[CAS_LAT-2]) ? '0 : {MSK_W{1'b1}};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_WAIT;
      cnt       <= CNT_W'(INIT_CYCLES - 1);
      ref_cnt   <= '0;
      ref_due   <= 1'b0;
      cmd       <= CMD_NOP;
      sd_cke    <= 1'b0;
      sd_ba     <= '0;
      sd_a      <= '0;
      sd_dq_o   <= '0;
      sd_dq_oe  <= 1'b0;
      wr_cyc    <= 1'b0;
      wr_q      <= 1'b0;
      col_q     <= '0;
      wdata_q   <= '0;
      rd_sr     <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      cmd      <= CMD_NOP;
      sd_cke   <= 1'b1;
      sd_dq_oe <= 1'b0;
      wr_cyc   <= 1'b0;
      rd_sr    <= {rd_sr[CAS_LAT-1:0], 1'b0};
      rsp_valid <= rd_sr[CAS_LAT];
      if (rd_sr[CAS_LAT]) rsp_rdata <= sd_dq_i;
      if (cnt != '0) cnt <= cnt - 1'b1;

      if (init_done) begin
        if (ref_cnt == RC_W'(REF_INTERVAL - 1)) begin
          ref_cnt <= '0;
          ref_due <= 1'b1;
        end else begin
          ref_cnt <= ref_cnt + 1'b1;
        end
      end

      if (cnt == '0) begin
        case (st)
          ST_WAIT, ST_IPRE: begin
            cmd  <= CMD_PRE;
            sd_a <= ROW_W'(1 << 10);
            cnt  <= CNT_W'(T_RP - 1);
            st   <= ST_IREF1;
          end
          ST_IREF1: begin
            cmd <= CMD_REF;
            cnt <= CNT_W'(T_RFC - 1);
            st  <= ST_IREF2;
          end
          ST_IREF2: begin
            cmd <= CMD_REF;
            cnt <= CNT_W'(T_RFC - 1);
            st  <= ST_IMRS;
          end
          ST_IMRS: begin
            cmd   <= CMD_MRS;
            sd_ba <= '0;
            sd_a  <= ROW_W'(CAS_LAT << 4);
            cnt   <= CNT_W'(T_MRD - 1);
            st    <= ST_IDLE;
          end
          ST_IDLE: begin
            if (ref_due) begin
              cmd  <= CMD_PRE;
              sd_a <= ROW_W'(1 << 10);
              cnt  <= CNT_W'(T_RP - 1);
              st   <= ST_RREF;
            end else if (req_valid) begin
              cmd     <= CMD_ACT;
              sd_ba   <= req_addr[BANK_W+ROW_W+COL_W-1 -: BANK_W];
              sd_a    <= req_addr[ROW_W+COL_W-1 -: ROW_W];
              col_q   <= req_addr[COL_W-1:0];
              wr_q    <= req_write;
              wdata_q <= req_wdata;
              cnt     <= CNT_W'(T_RCD - 1);
              st      <= ST_COL;
            end
          end
          ST_COL: begin
            sd_a <= ROW_W'(col_q) | ROW_W'(1 << 10);
            st   <= ST_IDLE;
            if (wr_q) begin
              cmd      <= CMD_WR;
              sd_dq_o  <= wdata_q;
              sd_dq_oe <= 1'b1;
              wr_cyc   <= 1'b1;
              cnt      <= CNT_W'(T_WR + T_RP - 1);
            end else begin
              cmd      <= CMD_RD;
              rd_sr[0] <= 1'b1;
              cnt      <= CNT_W'(CAS_LAT + T_RP - 1);
            end
          end
          ST_RREF: begin
            cmd     <= CMD_REF;
            ref_due <= 1'b0;
            cnt     <= CNT_W'(T_RFC - 1);
            st      <= ST_IDLE;
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

  a_r5_oe_in_write_only: assert property (@(posedge clk) disable iff (!rst_n)
    sd_dq_oe |-> (cmd == CMD_WR) && (sd_dqm == '0));

  a_r3_col_autoprecharge: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_RD) || (cmd == CMD_WR)) |-> sd_a[10]);

  a_r4_act_before_col: assert property (@(posedge clk) disable iff (!rst_n)
    ((cmd == CMD_RD) || (cmd == CMD_WR)) |-> ($past(cmd, T_RCD) == CMD_ACT));

  a_r8_nop_after_refresh: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_REF) |=> (cmd == CMD_NOP));

  a_r6_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);

  a_r1_ready_after_init: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> sd_cke);

endmodule

// File: tb/sdram_cmd_ctrl_tb.sv
module sdram_cmd_ctrl_tb;
  localparam int INIT_CYCLES = 50;
  localparam int REF_INT     = 300;
  localparam int T_RCD = 2, T_RP = 3, T_RFC = 6, T_WR = 2, T_MRD = 2, CAS_LAT = 3;
  localparam int SLACK = T_RCD + CAS_LAT + T_WR + 2 * T_RP + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_ready;
  logic [21:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic rsp_valid;
  logic [31:0] rsp_rdata;
  logic sd_cke, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0] sd_ba;
  logic [11:0] sd_a;
  logic [3:0] sd_dqm;
  logic [31:0] sd_dq_o;
  logic [31:0] sd_dq_i = '0;

  always #4 clk = ~clk;

  sdram_cmd_ctrl #(.INIT_CYCLES(INIT_CYCLES), .REF_INTERVAL(REF_INT), .T_RCD(T_RCD),
    .T_RP(T_RP), .T_RFC(T_RFC), .T_WR(T_WR), .T_MRD(T_MRD), .CAS_LAT(CAS_LAT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n), .sd_ba(sd_ba),
    .sd_a(sd_a), .sd_dqm(sd_dqm), .sd_dq_o(sd_dq_o), .sd_dq_oe(sd_dq_oe), .sd_dq_i(sd_dq_i));

  int n_vec = 0, n_err = 0;
  logic [31:0] shadow [int];
  logic [31:0] exp_q [$];
  logic [31:0] mem [int];
  int n_req = 0, n_act = 0, n_ref = 0;

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_vec++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_err);
    $finish;
  endtask

  // SDRAM model and protocol monitor
  int cyc = 0;
  int init_step = 0, last_cmd_cyc = 0;
  int act_cyc = -100, col_cyc = -100, col_gap = 0, rd_cyc = -100, wr_cyc = -100;
  int pre_cyc = -100, ref_cyc = -100, prev_ref = -1;
  bit in_ref = 0;
  bit open_b [4];
  int  open_row [4];
  int  rd_key = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] c;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      sd_dq_i <= 32'hBAD0_0000 | 32'(cyc);
      if (init_step < 4) begin
        chk(!req_ready, "R1 ready low during init", req_ready, 0);
        if (c != 4'b0111) begin
          case (init_step)
            0: begin
              chk(c == 4'b0010 && sd_a[10], "R2 first precharge-all", c, 4'b0010);
              chk(cyc == INIT_CYCLES, "R2 init wait", cyc, INIT_CYCLES);
            end
            1: chk(c == 4'b0001 && cyc - last_cmd_cyc == T_RP, "R2 first refresh", cyc - last_cmd_cyc, T_RP);
            2: chk(c == 4'b0001 && cyc - last_cmd_cyc == T_RFC, "R2 second refresh", cyc - last_cmd_cyc, T_RFC);
            default: begin
              chk(c == 4'b0000 && cyc - last_cmd_cyc == T_RFC, "R2 mode load timing", cyc - last_cmd_cyc, T_RFC);
              chk(sd_a == 12'(CAS_LAT << 4) && sd_ba == 0, "R2 mode value", sd_a, CAS_LAT << 4);
            end
          endcase
          init_step++;
          last_cmd_cyc = cyc;
        end
      end else begin
        if (c != 4'b0111) begin
          chk(cyc - col_cyc >= col_gap, "R7 recovery gap", cyc - col_cyc, col_gap);
          chk(cyc - ref_cyc >= T_RFC, "R8 quiet after refresh", cyc - ref_cyc, T_RFC);
        end
        case (c)
          4'b0011: begin
            n_act++;
            chk(!open_b[sd_ba], "R3 activate to idle bank", open_b[sd_ba], 0);
            open_b[sd_ba] = 1; open_row[sd_ba] = sd_a; act_cyc = cyc;
          end
          4'b0101, 4'b0100: begin
            chk(open_b[sd_ba], "R3 column to open bank", open_b[sd_ba], 1);
            chk(cyc - act_cyc == T_RCD, "R4 activate to column", cyc - act_cyc, T_RCD);
            chk(sd_a[10] && sd_a[11] == 0 && sd_a[9:8] == 0, "R3 column address bits", sd_a, 12'h400);
            rd_key = {sd_ba, open_row[sd_ba][11:0], sd_a[7:0]};
            open_b[sd_ba] = 0; col_cyc = cyc;
            if (c == 4'b0100) begin
              chk(sd_dq_oe, "R5 write drives DQ", sd_dq_oe, 1);
              mem[rd_key] = sd_dq_o; wr_cyc = cyc; col_gap = T_WR + T_RP;
            end else begin
              rd_cyc = cyc; col_gap = CAS_LAT + T_RP;
            end
          end
          4'b0010: begin
            chk(sd_a[10], "R8 precharge-all before refresh", sd_a[10], 1);
            pre_cyc = cyc; in_ref = 1;
          end
          4'b0001: begin
            chk(cyc - pre_cyc == T_RP, "R8 precharge to refresh", cyc - pre_cyc, T_RP);
            if (prev_ref >= 0)
              chk(cyc - prev_ref <= REF_INT + SLACK && cyc - prev_ref >= REF_INT - SLACK,
                  "R8 refresh interval", cyc - prev_ref, REF_INT);
            prev_ref = cyc; ref_cyc = cyc; n_ref++; in_ref = 0;
          end
          4'b0111: ;
          default: chk(0, "R3 illegal command", c, 4'b0111);
        endcase
        if (in_ref || c == 4'b0001) chk(!req_ready, "R9 ready low in refresh", req_ready, 0);
        chk(sd_dq_oe == (c == 4'b0100), "R5 DQ enable only on write", sd_dq_oe, c == 4'b0100);
        if (cyc == rd_cyc + CAS_LAT)
          sd_dq_i <= mem.exists(rd_key) ? mem[rd_key] : 32'h0;
        chk(rsp_valid == (cyc == rd_cyc + CAS_LAT + 1), "R6 response timing", rsp_valid,
            cyc == rd_cyc + CAS_LAT + 1);
      end
      chk(sd_dqm == (((cyc == wr_cyc) || (cyc == rd_cyc + CAS_LAT - 2)) ? 4'h0 : 4'hF),
          "R6 DQM pattern", sd_dqm, ((cyc == wr_cyc) || (cyc == rd_cyc + CAS_LAT - 2)) ? 4'h0 : 4'hF);
      cyc++;
    end
  end

  // Scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (exp_q.size() == 0) chk(0, "R10 unexpected response", rsp_rdata, 0);
      else begin
        logic [31:0] e;
        e = exp_q.pop_front();
        chk(rsp_rdata == e, "R10 read data", rsp_rdata, e);
      end
    end
  end

  task automatic do_req(input bit wr, input logic [21:0] addr, input logic [31:0] data);
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = addr; req_wdata = data;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    n_req++;
    if (wr) shadow[int'(addr)] = data;
    else exp_q.push_back(shadow.exists(int'(addr)) ? shadow[int'(addr)] : 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    chk(0, "R10 watchdog", 0, 1);
    finish_run();
  end

  initial begin
    logic [21:0] corners [5];
    corners[0] = 22'h000000; corners[1] = 22'h3FFFFF; corners[2] = {2'd1, 12'hABC, 8'h5A};
    corners[3] = {2'd2, 12'h800, 8'hFF}; corners[4] = {2'd3, 12'h001, 8'h00};
    repeat (3) @(negedge clk);
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1 reset NOP",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 4'b0111);
    chk(sd_dqm == 4'hF && !sd_cke && !req_ready && !rsp_valid, "R1 reset outputs",
        {sd_dqm, sd_cke, req_ready, rsp_valid}, 7'h78);
    @(posedge clk); #2 rst_n = 1;
    for (int i = 0; i < 5; i++) do_req(1, corners[i], 32'hC0DE_0000 + 32'(i * 4369));
    for (int i = 4; i >= 0; i--) do_req(0, corners[i], 0);
    for (int i = 0; i < 120; i++) begin
      logic [21:0] ad;
      ad = 22'((i * 7919 + 12345) ^ (i << 17));
      do_req(1, ad, 32'(i * 32'h01010101) ^ 32'h5A5A_A5A5);
      do_req(0, ad, 0);
      if (i % 3 == 0) do_req(0, corners[i % 5], 0);
    end
    do_req(1, corners[2], 32'hFEED_BEEF);
    do_req(0, corners[2], 0);
    repeat (2 * REF_INT + 40) @(negedge clk);
    chk(exp_q.size() == 0, "R10 all responses returned", exp_q.size(), 0);
    chk(n_act == n_req, "R10 one activate per request", n_act, n_req);
    chk(n_ref >= 4, "R8 refreshes issued", n_ref, 4);
    finish_run();
  end
endmodule